// File: doc/BRIEF.md
# EEPROM Write-Protect Command Sequencer

This block sits in the write path of a byte-wide EEPROM, ahead of the page buffer. It examines every byte-load write, an address and data pair, one per clock at most. It recognises two magic address/data handshakes. A three-write unlock arms protection and opens a single page-load window. A six-write release sequence disarms protection after a fixed settling delay. It decides per write whether the byte goes on to the page buffer, is consumed as a command, or is discarded. Command bytes never reach the buffer.

Writes that might be the start of a command are held back, up to two of them. When the next write shows they are not a command, the held writes are released in arrival order together with the breaking write. Released writes leave as a registered group of up to three slots, one cycle after the write that settles them. The protect flag behaves as nonvolatile state. A persistence input loads it on reset, and the block reports it together with a window-open flag. Page programming completion is signalled by an input pulse that closes the window.

Top module: `wp_seq_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it, `prot_on` equals `persist_prot`, `win_open` is 0 and `rel_vld` is 0.
- R2: When unprotected and idle, a write that cannot start a command appears one cycle later with `rel_vld`=3'b001 and its address and data unchanged in slot 0 (`rel_addr[15:0]`, `rel_data[7:0]`). A cycle with no write releases nothing.
- R3: Command compares use only address bits 14..0 and all eight data bits. Address bit 15 has no effect on matching.
- R4: The unlock sequence is 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. None of its writes is released. In the cycle after the third write, `prot_on`=1 and `win_open`=1.
- R5: While the window is open, writes bypass command matching and are released in slot 0, up to `PAGE_BYTES` of them (default 128). Later writes are dropped. A `page_done` pulse while the window is open closes it on the next cycle.
- R6: While protected with the window closed, no write is ever released.
- R7: When unprotected, the first and second writes of a partial sequence are held (`rel_vld`=0). On a breaking write, the held writes fill the low slots oldest first, and the breaking write takes the next slot.
- R8: A breaking write that is itself 0xAA at 0x5555 is held as a new first command write, not released. A sequence completed from it is honoured.
- R9: The release sequence is 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. None of these writes is released. `prot_on` falls exactly `CLR_CYCLES` clock edges (default 8) after the edge that accepts the sixth write, and stays 1 until then.
- R10: When protected, a write that breaks a partial sequence is dropped, and the held command writes are discarded.
- R11: The third release write (0x80 at 0x5555) confirms the first three writes as a command and consumes them. If the sequence then breaks while unprotected, only the writes after the third are released, followed by the breaking write.
- R12: An unlock issued while unprotected turns protection on. Protection stays on after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| persist_prot | input | 1 | Stored protect state loaded on reset |
| wr_valid | input | 1 | A byte-load write is present this cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| page_done | input | 1 | Page programming finished (pulse) |
| rel_vld | output | 3 | Valid mask of released writes, slot 0 oldest |
| rel_addr | output | 48 | Released addresses, slot i at bits [16i+15:16i] |
| rel_data | output | 24 | Released data, slot i at bits [8i+7:8i] |
| prot_on | output | 1 | Protection currently in force |
| win_open | output | 1 | Single page-load window is open |

## Verification
The assertions assume that at most one write arrives per clock. They also assume that `page_done` matters only while a window is open, and that `persist_prot` does not change in the cycle reset is released. Under those assumptions the holding register can never overflow, and the block never releases anything while it is locked. The stimulus drives each write for exactly one cycle with idle cycles only where timing is measured. It pulses `page_done` only after a window has been opened, and it changes `persist_prot` only while reset is asserted.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int HOLD_DEPTH = 2;
    localparam int SLOTS      = HOLD_DEPTH + 1;

    localparam logic [14:0] KEY_ADDR_HI = 15'h5555;
    localparam logic [14:0] KEY_ADDR_LO = 15'h2AAA;
    localparam logic [7:0]  KEY_LEAD    = 8'hAA;
    localparam logic [7:0]  KEY_SECOND  = 8'h55;
    localparam logic [7:0]  KEY_ARM     = 8'hA0;
    localparam logic [7:0]  KEY_ESC     = 8'h80;
    localparam logic [7:0]  KEY_DISARM  = 8'h20;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    // matcher progress: number of command writes seen so far
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_LEAD, SQ_SECOND, SQ_ESC, SQ_LEAD2, SQ_SECOND2
    } seq_e;

    // what the holding stage does with held writes and the current one
    typedef enum logic [2:0] {
        HB_NONE, HB_PUSH, HB_ABSORB, HB_FLUSH_KEEP, HB_FLUSH
    } hb_e;

    typedef enum logic [1:0] {EV_NONE, EV_ARM, EV_DISARM} ev_e;

    // bit 15 of the address never takes part in a command compare
    function automatic logic key_hit(wr_t w, logic [14:0] a, logic [7:0] d);
        return (w.addr[14:0] == a) && (w.data == d);
    endfunction

endpackage

// File: rtl/wpseq_match.sv
module wpseq_match
    import wpseq_pkg::*;
(
    input  logic  wr_valid,
    input  wr_t   w,
    input  seq_e  seq_q,
    output seq_e  seq_d,
    output hb_e   hb,
    output ev_e   ev
);
    logic restart;

    always_comb begin
        restart = key_hit(w, KEY_ADDR_HI, KEY_LEAD);
        seq_d   = seq_q;
        hb      = HB_NONE;
        ev      = EV_NONE;
        if (wr_valid) begin
            // default: the write breaks whatever was matched
            seq_d = restart ? SQ_LEAD : SQ_IDLE;
            hb    = restart ? HB_FLUSH_KEEP : HB_FLUSH;
            unique case (seq_q)
                SQ_IDLE: if (restart) begin
                    seq_d = SQ_LEAD;  hb = HB_PUSH;
                end
                SQ_LEAD: if (key_hit(w, KEY_ADDR_LO, KEY_SECOND)) begin
                    seq_d = SQ_SECOND; hb = HB_PUSH;
                end
                SQ_SECOND: if (key_hit(w, KEY_ADDR_HI, KEY_ARM)) begin
                    seq_d = SQ_IDLE; hb = HB_ABSORB; ev = EV_ARM;
                end else if (key_hit(w, KEY_ADDR_HI, KEY_ESC)) begin
                    seq_d = SQ_ESC;  hb = HB_ABSORB;
                end
                SQ_ESC: if (restart) begin
                    seq_d = SQ_LEAD2; hb = HB_PUSH;
                end
                SQ_LEAD2: if (key_hit(w, KEY_ADDR_LO, KEY_SECOND)) begin
                    seq_d = SQ_SECOND2; hb = HB_PUSH;
                end
                SQ_SECOND2: if (key_hit(w, KEY_ADDR_HI, KEY_DISARM)) begin
                    seq_d = SQ_IDLE; hb = HB_ABSORB; ev = EV_DISARM;
                end
                default: begin
                    seq_d = SQ_IDLE; hb = HB_FLUSH;
                end
            endcase
        end
    end

endmodule

// File: rtl/wpseq_hold.sv
module wpseq_hold
    import wpseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  hb_e              hb,
    input  logic             allow,
    input  wr_t              w,
    output logic [SLOTS-1:0] rel_vld,
    output wr_t [SLOTS-1:0]  rel_w
);
    localparam int CNT_W = $clog2(HOLD_DEPTH + 1);

    logic [CNT_W-1:0]     h_cnt, n_cnt;
    wr_t [HOLD_DEPTH-1:0] h_buf, n_buf;
    logic [SLOTS-1:0]     o_vld;
    wr_t [SLOTS-1:0]      o_w;

    always_comb begin
        n_cnt = h_cnt;
        n_buf = h_buf;
        o_vld = '0;
        o_w   = '0;
        unique case (hb)
            HB_PUSH: begin
                for (int i = 0; i < HOLD_DEPTH; i++)
                    if (CNT_W'(i) == h_cnt) n_buf[i] = w;
                n_cnt = h_cnt + 1'b1;
            end
            HB_ABSORB: n_cnt = '0;
            HB_FLUSH_KEEP, HB_FLUSH: begin
                if (allow) begin
                    for (int i = 0; i < HOLD_DEPTH; i++)
                        if (CNT_W'(i) < h_cnt) begin
                            o_vld[i] = 1'b1;
                            o_w[i]   = h_buf[i];
                        end
                    if (hb == HB_FLUSH)
                        for (int i = 0; i < SLOTS; i++)
                            if (CNT_W'(i) == h_cnt) begin
                                o_vld[i] = 1'b1;
                                o_w[i]   = w;
                            end
                end
                if (hb == HB_FLUSH_KEEP) begin
                    n_buf[0] = w;
                    n_cnt    = CNT_W'(1);
                end else begin
                    n_cnt = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt   <= '0;
            h_buf   <= '0;
            rel_vld <= '0;
            rel_w   <= '0;
        end else begin
            h_cnt   <= n_cnt;
            h_buf   <= n_buf;
            rel_vld <= o_vld;
            rel_w   <= o_w;
        end
    end

    AST_HOLD_ROOM: assert property (@(posedge clk) disable iff (rst)
        hb == HB_PUSH |-> h_cnt < CNT_W'(HOLD_DEPTH)); // R7

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wpseq_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int CLR_CYCLES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     persist_prot,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     page_done,
    output logic [SLOTS-1:0]         rel_vld,
    output logic [SLOTS*ADDR_W-1:0]  rel_addr,
    output logic [SLOTS*DATA_W-1:0]  rel_data,
    output logic                     prot_on,
    output logic                     win_open
);
    localparam int WCNT_W = $clog2(PAGE_BYTES + 1);
    localparam int PEND_W = $clog2(CLR_CYCLES + 1);

    wr_t              w_in;
    seq_e             seq_q, seq_d;
    hb_e              hb_m, hb_eff;
    ev_e              ev_m, ev_eff;
    logic             prot_q, win_q, allow;
    logic [WCNT_W-1:0] cnt_q;
    logic [PEND_W-1:0] pend_q;
    wr_t [SLOTS-1:0]  rel_w;

    assign w_in = '{addr: wr_addr, data: wr_data};

    wpseq_match u_match (
        .wr_valid (wr_valid),
        .w        (w_in),
        .seq_q    (seq_q),
        .seq_d    (seq_d),
        .hb       (hb_m),
        .ev       (ev_m)
    );

    // an open window bypasses command matching entirely
    assign hb_eff = win_q ? (wr_valid ? HB_FLUSH : HB_NONE) : hb_m;
    assign ev_eff = win_q ? EV_NONE : ev_m;
    assign allow  = win_q ? (cnt_q < WCNT_W'(PAGE_BYTES)) : !prot_q;

    wpseq_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .hb      (hb_eff),
        .allow   (allow),
        .w       (w_in),
        .rel_vld (rel_vld),
        .rel_w   (rel_w)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign rel_addr[g*ADDR_W +: ADDR_W] = rel_w[g].addr;
        assign rel_data[g*DATA_W +: DATA_W] = rel_w[g].data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= SQ_IDLE;
            prot_q <= persist_prot;
            win_q  <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            if (!win_q) seq_q <= seq_d;
            if (win_q && wr_valid && allow) cnt_q <= cnt_q + 1'b1;
            if (win_q && page_done) win_q <= 1'b0;
            if (ev_eff == EV_ARM) begin
                prot_q <= 1'b1;
                win_q  <= 1'b1;
                cnt_q  <= '0;
                pend_q <= '0;
            end else if (ev_eff == EV_DISARM) begin
                pend_q <= PEND_W'(CLR_CYCLES);
            end else if (pend_q == PEND_W'(1)) begin
                prot_q <= 1'b0;
                pend_q <= '0;
            end else if (pend_q != '0) begin
                pend_q <= pend_q - 1'b1;
            end
        end
    end

    assign prot_on  = prot_q;
    assign win_open = win_q;

    AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        prot_q && !win_q |=> rel_vld == '0); // R6
    AST_ARM_OPENS: assert property (@(posedge clk) disable iff (rst)
        ev_eff == EV_ARM |=> prot_q && win_q); // R4
    AST_WIN_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= WCNT_W'(PAGE_BYTES)); // R5
    AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (rst)
        win_q && page_done |=> !win_q); // R5
    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> rel_vld == '0); // R2
    AST_CLEAR_DELAY: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_q) |-> $past(pend_q) == PEND_W'(1)); // R9

endmodule

// File: tb/sim_wp_seq_guard.sv
module sim_wp_seq_guard;
    localparam int CLK_PERIOD = 10;
    localparam int CLR        = 8;
    localparam int PAGE       = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        persist_prot = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_done = 1'b0;
    logic [2:0]  rel_vld;
    logic [47:0] rel_addr;
    logic [23:0] rel_data;
    logic        prot_on, win_open;

    logic [2:0]  got_vld;
    logic [47:0] got_addr;
    logic [23:0] got_data;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_seq_guard #(.PAGE_BYTES(PAGE), .CLR_CYCLES(CLR)) u0 (
        .clk(clk), .rst(rst), .persist_prot(persist_prot),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_done(page_done), .rel_vld(rel_vld), .rel_addr(rel_addr),
        .rel_data(rel_data), .prot_on(prot_on), .win_open(win_open)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        got_vld = rel_vld; got_addr = rel_addr; got_data = rel_data;
    endtask

    task automatic do_reset(input logic p);
        rst = 1'b1; persist_prot = p;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        page_done = 1'b1;
        @(negedge clk);
        page_done = 1'b0;
    endtask

    function automatic logic [15:0] dis_a(input int k);
        return (k == 1 || k == 4) ? 16'h2AAA : 16'h5555;
    endfunction
    function automatic logic [7:0] dis_d(input int k);
        case (k)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2: return 8'h80;
            default: return 8'h20;
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset values, both persistence settings
        do_reset(1'b1);
        chk("R1 prot", prot_on, 1); chk("R1 win", win_open, 0); chk("R1 vld", rel_vld, 0);
        do_reset(1'b0);
        chk("R1 prot", prot_on, 0); chk("R1 win", win_open, 0); chk("R1 vld", rel_vld, 0);

        // R2 plain writes pass through when open
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a; logic [7:0] d;
            a = 16'(i * 16'h1111); d = 8'(i * 17 + 3);
            wr(a, d);
            chk("R2 vld", got_vld, 3'b001);
            chk("R2 addr", got_addr[15:0], a);
            chk("R2 data", got_data[7:0], d);
        end
        @(negedge clk);
        chk("R2 idle", rel_vld, 0);

        // R3 R4 R12 unlock with bit 15 set, from open mode
        wr(16'hD555, 8'hAA); chk("R4 absorb1", got_vld, 0);
        wr(16'hAAAA, 8'h55); chk("R4 absorb2", got_vld, 0);
        wr(16'hD555, 8'hA0); chk("R4 absorb3", got_vld, 0);
        chk("R3 R12 prot", prot_on, 1); chk("R4 win", win_open, 1);

        // R5 window limit
        for (int i = 0; i < PAGE + 2; i++) begin
            wr(16'(16'h1200 + i), 8'(i));
            chk("R5 window", got_vld, (i < PAGE) ? 3'b001 : 3'b000);
        end
        pulse_done();
        chk("R5 close", win_open, 0); chk("R12 stays", prot_on, 1);

        // R6 R10 protected drops
        wr(16'h0300, 8'h12); chk("R6 drop", got_vld, 0);
        wr(16'h5555, 8'hAA); chk("R10 held", got_vld, 0);
        wr(16'h0400, 8'h34); chk("R10 break", got_vld, 0);
        // R8 restart while protected then complete unlock
        wr(16'h5555, 8'hAA); wr(16'h5555, 8'hAA); chk("R8 restart", got_vld, 0);
        wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
        chk("R8 win", win_open, 1);
        pulse_done();
        chk("R8 close", win_open, 0);

        // R9 release sequence and delay
        for (int k = 0; k < 6; k++) begin
            wr(dis_a(k), dis_d(k)); chk("R9 absorb", got_vld, 0);
        end
        repeat (CLR - 1) @(negedge clk);
        chk("R9 still", prot_on, 1);
        @(negedge clk);
        chk("R9 clear", prot_on, 0);
        wr(16'h0055, 8'h66); chk("R9 open", got_vld, 3'b001);

        // R7 R11 break sweep over release sequence positions
        for (int p = 0; p < 6; p++) begin
            int e;
            e = (p <= 2) ? p : p - 3;
            for (int k = 0; k < p; k++) begin
                wr(dis_a(k), dis_d(k)); chk("R7 held", got_vld, 0);
            end
            wr(16'h0123, 8'h5A);
            chk((p >= 3) ? "R11 vld" : "R7 vld", got_vld, (1 << (e + 1)) - 1);
            chk("R7 last", got_addr[e*16 +: 16], 16'h0123);
            if (e > 0) chk((p >= 3) ? "R11 first" : "R7 first",
                           got_addr[15:0], dis_a((p <= 2) ? 0 : 3));
        end

        // R8 restart while open
        wr(16'h5555, 8'hAA); wr(16'h5555, 8'hAA);
        chk("R8 vld", got_vld, 3'b001);
        chk("R8 addr", got_addr[15:0], 16'h5555); chk("R8 data", got_data[7:0], 8'hAA);
        wr(16'h0777, 8'h01);
        chk("R8 flush", got_vld, 3'b011);
        chk("R8 slot1", got_addr[31:16], 16'h0777);

        done = 1;
        summary();
    end
endmodule